// File: doc/BRIEF.md
# EPROM Write Command Sequencer

This block is the byte-level slave side of a write path into a one-time-programmable memory. The memory has two fields: a large data field and a small status field. A master sends a command byte, a two-byte start address and then data bytes. For each data byte the block can return a CRC-16 check value, then waits for a program strobe. On the strobe it clears bits in the addressed cell, returns the resulting cell contents, and moves to the next address. Each field has a normal command and a faster command that leaves out the CRC before the program strobe.

The serial bit-slot layer is not part of this block. Received bytes arrive with a one-cycle valid strobe, and returned bytes leave the same way. A bus-reset input aborts any sequence and returns the block to waiting for a command. The memory contents are kept through a bus reset. Only the chip reset (`rst_n`) erases the array to all ones.

Top module: `otpWriteSeq`

## Requirements
- R1: The command byte selects the field and the variant. 0x0F is a data write with CRC. 0xF3 is a data write without CRC. 0x55 is a status write with CRC. 0xF5 is a status write without CRC.
- R2: The start address is received low byte first, then high byte. Bits 15..13 of the received address are forced to zero. The data store holds DATA_WORDS bytes and is indexed by address modulo DATA_WORDS. Address increments wrap from 0x1FFF to 0x0000.
- R3: After the first data byte of a normal command, the block returns two bytes: the low byte and then the high byte of the inverted CRC. The CRC uses polynomial x^16+x^15+x^2+1, bit-reflected and processed LSB first, starting from zero. It covers the command byte, the address low byte, the masked address high byte and the data byte.
- R4: A speed command returns no CRC bytes. The block waits for the program strobe directly after the data byte.
- R5: A program strobe received while the block is waiting for it replaces the addressed cell with (old AND data). The block then returns exactly one byte, which is the new cell contents.
- R6: After that returned byte, the address always increments, even when the cell differs from the data sent. For each later byte of a normal command, the CRC restarts from the incremented 16-bit address value and then takes in the new data byte.
- R7: Status addresses at or above STAT_WORDS are not implemented. A write to one of them leaves every cell unchanged and returns 0xFF.
- R8: A bus reset, in any state, returns the block to waiting for a command. Nothing is programmed unless a program strobe arrives while the block is waiting for one.
- R9: An unknown command byte makes the block ignore all further bytes and strobes until the next bus reset.
- R10: A program strobe while the block is waiting for a byte is ignored. A received byte while the block is waiting for a program strobe is ignored.
- R11: After chip reset, no byte is being returned and every cell reads 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low chip reset; erases the array |
| busReset | input | 1 | Aborts the current sequence and returns to command wait |
| rxValid | input | 1 | One-cycle strobe marking a received byte |
| rxByte | input | 8 | Received byte |
| progPulse | input | 1 | Program strobe |
| txValid | output | 1 | One-cycle strobe marking a returned byte |
| txByte | output | 8 | Returned byte (CRC or readback) |

## Verification
The bench builds the block with DATA_WORDS=16 and STAT_WORDS=12. With these sizes it can program every data cell and every status location, including two unimplemented status locations, and read each one back. Address folding, truncation of a high start address and the wrap from 0x1FFF to 0x0000 can all be driven directly at these sizes. Runs of several bytes then cross the data-store fold, the edge of the implemented status region and cells that were already programmed. This exercises readback mismatches together with the CRC restart from each new address.

// File: rtl/otpSeqPkg.sv
package otpSeqPkg;
  localparam int ADDR_BITS = 13;

  localparam logic [7:0] OP_DATA_CRC  = 8'h0F;
  localparam logic [7:0] OP_DATA_FAST = 8'hF3;
  localparam logic [7:0] OP_STAT_CRC  = 8'h55;
  localparam logic [7:0] OP_STAT_FAST = 8'hF5;

  typedef enum logic [3:0] {
    S_CMD, S_ALO, S_AHI, S_DATA, S_CRCL, S_CRCH, S_WAIT, S_RB, S_DEAD
  } seqState_t;

  typedef enum logic [1:0] {TX_NONE, TX_CRCL, TX_CRCH, TX_RB} txSel_t;

  typedef struct packed {
    logic   crcStart;
    logic   crcAcc;
    logic   maskHi;
    logic   ldAddrLo;
    logic   ldAddrHi;
    logic   ldData;
    logic   commit;
    logic   advance;
    logic   isStatus;
    txSel_t txSel;
  } ctrlStrb_t;

  function automatic logic [15:0] crc16Step(input logic [15:0] crcIn, input logic [7:0] b);
    logic [15:0] c;
    c = crcIn;
    for (int i = 0; i < 8; i++) begin
      if (c[0] ^ b[i]) c = (c >> 1) ^ 16'hA001;
      else             c = c >> 1;
    end
    return c;
  endfunction
endpackage

// File: rtl/otpSeqCtrl.sv
module otpSeqCtrl
  import otpSeqPkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       busReset,
  input  logic       rxValid,
  input  logic [7:0] rxByte,
  input  logic       progPulse,
  output ctrlStrb_t  strb
);
  seqState_t state;
  logic      isStatus;
  logic      isFast;
  logic      knownOp;

  assign knownOp = (rxByte == OP_DATA_CRC) || (rxByte == OP_DATA_FAST) ||
                   (rxByte == OP_STAT_CRC) || (rxByte == OP_STAT_FAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_CMD;
      isStatus <= 1'b0;
      isFast   <= 1'b0;
    end else if (busReset) begin
      state <= S_CMD;
    end else begin
      case (state)
        S_CMD: if (rxValid) begin
          if (knownOp) begin
            isStatus <= (rxByte == OP_STAT_CRC) || (rxByte == OP_STAT_FAST);
            isFast   <= (rxByte == OP_DATA_FAST) || (rxByte == OP_STAT_FAST);
            state    <= S_ALO;
          end else begin
            state <= S_DEAD;
          end
        end
        S_ALO:  if (rxValid) state <= S_AHI;
        S_AHI:  if (rxValid) state <= S_DATA;
        S_DATA: if (rxValid) state <= isFast ? S_WAIT : S_CRCL;
        S_CRCL: state <= S_CRCH;
        S_CRCH: state <= S_WAIT;
        S_WAIT: if (progPulse) state <= S_RB;
        S_RB:   state <= S_DATA;
        default: state <= S_DEAD;
      endcase
    end
  end

  always_comb begin
    strb          = '0;
    strb.txSel    = TX_NONE;
    strb.isStatus = isStatus;
    if (!busReset) begin
      case (state)
        S_CMD:  strb.crcStart = rxValid && knownOp;
        S_ALO:  begin strb.ldAddrLo = rxValid; strb.crcAcc = rxValid; end
        S_AHI:  begin strb.ldAddrHi = rxValid; strb.crcAcc = rxValid; strb.maskHi = 1'b1; end
        S_DATA: begin strb.ldData = rxValid; strb.crcAcc = rxValid; end
        S_CRCL: strb.txSel = TX_CRCL;
        S_CRCH: strb.txSel = TX_CRCH;
        S_WAIT: strb.commit = progPulse;
        S_RB:   begin strb.txSel = TX_RB; strb.advance = 1'b1; end
        default: ;
      endcase
    end
  end

  a_r8_abort: assert property (@(posedge clk) disable iff (!rst_n)
    busReset |=> state == S_CMD);
  a_r4_speed_skip: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_DATA && rxValid && isFast && !busReset) |=> state == S_WAIT);
  a_r3_crc_first: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_DATA && rxValid && !isFast && !busReset) |=> state == S_CRCL);
  a_r9_dead_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_DEAD && !busReset) |=> state == S_DEAD);
endmodule

// File: rtl/otpSeqDatapath.sv
module otpSeqDatapath
  import otpSeqPkg::*;
#(
  parameter int DATA_WORDS = 512,
  parameter int STAT_WORDS = 352
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] rxByte,
  input  ctrlStrb_t  strb,
  output logic       txValid,
  output logic [7:0] txByte
);
  localparam int DIDX = (DATA_WORDS > 1) ? $clog2(DATA_WORDS) : 1;
  localparam int SIDX = (STAT_WORDS > 1) ? $clog2(STAT_WORDS) : 1;
  localparam logic [ADDR_BITS-1:0] STAT_LIM = ADDR_BITS'(STAT_WORDS);

  logic [ADDR_BITS-1:0] addr;
  logic [ADDR_BITS-1:0] nextAddr;
  logic [15:0]          crc;
  logic [7:0]           dataReg;
  logic [7:0]           accByte;
  logic [7:0]           rdVal;
  logic                 statHit;
  logic [DIDX-1:0]      dIdx;
  logic [SIDX-1:0]      sIdx;
  logic [7:0]           dataMem [DATA_WORDS];
  logic [7:0]           statMem [STAT_WORDS];

  assign nextAddr = addr + 1'b1;
  assign accByte  = strb.maskHi ? {3'b000, rxByte[4:0]} : rxByte;
  assign statHit  = addr < STAT_LIM;
  assign dIdx     = addr[DIDX-1:0];
  assign sIdx     = addr[SIDX-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr    <= '0;
      crc     <= '0;
      dataReg <= '0;
    end else begin
      if (strb.crcStart)     crc <= crc16Step(16'h0000, rxByte);
      else if (strb.crcAcc)  crc <= crc16Step(crc, accByte);
      else if (strb.advance) crc <= 16'(nextAddr);
      if (strb.ldAddrLo) addr[7:0] <= rxByte;
      if (strb.ldAddrHi) addr[ADDR_BITS-1:8] <= rxByte[ADDR_BITS-9:0];
      if (strb.advance)  addr <= nextAddr;
      if (strb.ldData)   dataReg <= rxByte;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DATA_WORDS; i++) dataMem[i] <= 8'hFF;
      for (int i = 0; i < STAT_WORDS; i++) statMem[i] <= 8'hFF;
    end else if (strb.commit) begin
      if (!strb.isStatus)  dataMem[dIdx] <= dataMem[dIdx] & dataReg;
      else if (statHit)    statMem[sIdx] <= statMem[sIdx] & dataReg;
    end
  end

  always_comb begin
    if (!strb.isStatus) rdVal = dataMem[dIdx];
    else if (statHit)   rdVal = statMem[sIdx];
    else                rdVal = 8'hFF;
  end

  always_comb begin
    txValid = strb.txSel != TX_NONE;
    case (strb.txSel)
      TX_CRCL: txByte = ~crc[7:0];
      TX_CRCH: txByte = ~crc[15:8];
      TX_RB:   txByte = rdVal;
      default: txByte = 8'h00;
    endcase
  end

  a_r6_step: assert property (@(posedge clk) disable iff (!rst_n)
    strb.advance |=> addr == $past(nextAddr));
  a_r5_clear_only: assert property (@(posedge clk) disable iff (!rst_n)
    strb.commit |=> (rdVal & ~$past(rdVal)) == 8'h00);
endmodule

// File: rtl/otpWriteSeq.sv
module otpWriteSeq
  import otpSeqPkg::*;
#(
  parameter int DATA_WORDS = 512,
  parameter int STAT_WORDS = 352
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       busReset,
  input  logic       rxValid,
  input  logic [7:0] rxByte,
  input  logic       progPulse,
  output logic       txValid,
  output logic [7:0] txByte
);
  ctrlStrb_t strb;

  otpSeqCtrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .busReset(busReset), .rxValid(rxValid),
    .rxByte(rxByte), .progPulse(progPulse), .strb(strb)
  );

  otpSeqDatapath #(.DATA_WORDS(DATA_WORDS), .STAT_WORDS(STAT_WORDS)) u_dp (
    .clk(clk), .rst_n(rst_n), .rxByte(rxByte), .strb(strb),
    .txValid(txValid), .txByte(txByte)
  );
endmodule

// File: tb/otpWriteSeq_tb.sv
`timescale 1ns/1ps
module otpWriteSeq_tb;
  localparam int DW = 16;
  localparam int SW = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic busReset = 1'b0;
  logic rxValid = 1'b0;
  logic [7:0] rxByte = 8'h00;
  logic progPulse = 1'b0;
  logic txValid;
  logic [7:0] txByte;

  int total = 0;
  int bad = 0;
  bit done = 0;
  logic [7:0] txQ[$];
  logic [7:0] expData [DW];
  logic [7:0] expStat [SW];

  always #2 clk = ~clk;

  otpWriteSeq #(.DATA_WORDS(DW), .STAT_WORDS(SW)) u_dut (
    .clk(clk), .rst_n(rst_n), .busReset(busReset), .rxValid(rxValid),
    .rxByte(rxByte), .progPulse(progPulse), .txValid(txValid), .txByte(txByte)
  );

  always @(negedge clk) if (rst_n && txValid) txQ.push_back(txByte);

  function automatic logic [15:0] rev16(input logic [15:0] v);
    logic [15:0] r;
    for (int i = 0; i < 16; i++) r[i] = v[15-i];
    return r;
  endfunction

  // Forward-form CRC (poly 0x8005, MSB first) on the bit-reversed register
  function automatic logic [15:0] refCrc(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] r;
    r = rev16(c);
    for (int i = 0; i < 8; i++) begin
      if (r[15] ^ b[i]) r = (r << 1) ^ 16'h8005;
      else              r = r << 1;
    end
    return rev16(r);
  endfunction

  task automatic chk(input bit ok, input string msg, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", msg, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic sendByte(input logic [7:0] b);
    @(negedge clk); rxValid = 1'b1; rxByte = b;
    @(negedge clk); rxValid = 1'b0;
  endtask

  task automatic pulse();
    @(negedge clk); progPulse = 1'b1;
    @(negedge clk); progPulse = 1'b0;
  endtask

  task automatic busRst();
    @(negedge clk); busReset = 1'b1;
    @(negedge clk); busReset = 1'b0;
  endtask

  task automatic runWrite(input logic [7:0] cmd, input logic [15:0] raw, input int n,
                          input logic [7:0] seed, input bit allOnes, input string tag);
    bit normal, stat;
    logic [15:0] crc;
    logic [12:0] eff;
    logic [7:0] d, exp;
    normal = (cmd == 8'h0F) || (cmd == 8'h55);
    stat   = (cmd == 8'h55) || (cmd == 8'hF5);
    eff = raw[12:0];
    crc = refCrc(16'h0000, cmd);
    crc = refCrc(crc, raw[7:0]);
    crc = refCrc(crc, {3'b000, raw[12:8]});
    sendByte(cmd); sendByte(raw[7:0]); sendByte(raw[15:8]);
    for (int i = 0; i < n; i++) begin
      d = allOnes ? 8'hFF : 8'(seed + 8'(i * 53));
      if (i > 0) crc = {3'b000, eff};
      crc = refCrc(crc, d);
      txQ = {};
      sendByte(d);
      idle(3);
      if (normal) begin
        chk(txQ.size() == 2, {tag, " R3 crc byte count"}, txQ.size(), 2);
        if (txQ.size() == 2) begin
          chk(txQ[0] == ~crc[7:0], {tag, " R3 R6 crc low"}, txQ[0], ~crc[7:0]);
          chk(txQ[1] == ~crc[15:8], {tag, " R3 R6 crc high"}, txQ[1], ~crc[15:8]);
        end
      end else begin
        chk(txQ.size() == 0, {tag, " R4 no crc in speed mode"}, txQ.size(), 0);
      end
      txQ = {};
      pulse();
      idle(2);
      if (stat) begin
        if (eff < 13'(SW)) begin
          expStat[eff] = expStat[eff] & d;
          exp = expStat[eff];
        end else exp = 8'hFF;
      end else begin
        expData[eff % DW] = expData[eff % DW] & d;
        exp = expData[eff % DW];
      end
      chk(txQ.size() == 1, {tag, " R5 readback count"}, txQ.size(), 1);
      if (txQ.size() == 1)
        chk(txQ[0] == exp, {tag, " R5 R6 R7 readback value"}, txQ[0], exp);
      txQ = {};
      eff = eff + 13'd1;
    end
    busRst();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < DW; i++) expData[i] = 8'hFF;
    for (int i = 0; i < SW; i++) expStat[i] = 8'hFF;
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);
    chk(txValid == 1'b0, "R11 no output after reset", txValid, 0);

    // R11: erased array, whole data field and status field including unimplemented
    runWrite(8'hF3, 16'h0000, DW, 8'h00, 1'b1, "R11 data erased");
    runWrite(8'hF5, 16'h0000, SW + 2, 8'h00, 1'b1, "R11 status erased");

    // R1/R3: each opcode, several address and data patterns
    runWrite(8'h0F, 16'h0003, 4, 8'h5A, 1'b0, "R1 data normal");
    runWrite(8'h55, 16'h0002, 3, 8'hC3, 1'b0, "R1 status normal");
    runWrite(8'hF3, 16'h0009, 3, 8'h77, 1'b0, "R1 data speed");
    runWrite(8'hF5, 16'h0005, 3, 8'hE1, 1'b0, "R1 status speed");

    // R2: top bits masked, fold, and wrap past 0x1FFF
    runWrite(8'hF3, 16'hE00E, 4, 8'h3F, 1'b0, "R2 truncated start");
    runWrite(8'h0F, 16'hFFFE, 3, 8'hB6, 1'b0, "R2 wrap 1FFF");

    // R7: crosses the end of the implemented status region
    runWrite(8'h55, 16'h000A, 4, 8'h9C, 1'b0, "R7 status edge");
    runWrite(8'hF5, 16'h0000, 2, 8'h00, 1'b1, "R7 no alias at base");

    // R6: reprogramming already programmed cells, readback differs from data
    runWrite(8'h0F, 16'h0003, 3, 8'h0F, 1'b0, "R6 mismatch continue");

    // R8: abort while returning CRC, then a stray strobe
    sendByte(8'h0F); sendByte(8'h05); sendByte(8'h00); sendByte(8'h00);
    busRst(); pulse(); idle(2);
    txQ = {};
    runWrite(8'hF3, 16'h0005, 1, 8'h00, 1'b1, "R8 abort in crc");
    // R8: abort while waiting for the strobe
    sendByte(8'hF3); sendByte(8'h06); sendByte(8'h00); sendByte(8'h00);
    busRst(); pulse(); idle(2);
    txQ = {};
    runWrite(8'hF3, 16'h0006, 1, 8'h00, 1'b1, "R8 abort in wait");

    // R9: unknown opcode locks out until bus reset
    txQ = {};
    sendByte(8'hAA); sendByte(8'h0F); sendByte(8'h07); sendByte(8'h00); sendByte(8'h00);
    pulse(); idle(3);
    chk(txQ.size() == 0, "R9 nothing returned after unknown opcode", txQ.size(), 0);
    busRst();
    runWrite(8'hF3, 16'h0007, 1, 8'h00, 1'b1, "R9 cell untouched");

    // R10: strobe before data and byte during wait are ignored
    txQ = {};
    sendByte(8'hF3); sendByte(8'h08); sendByte(8'h00);
    pulse(); idle(2);
    chk(txQ.size() == 0, "R10 early strobe ignored", txQ.size(), 0);
    sendByte(8'h3C); sendByte(8'h00); idle(2);
    chk(txQ.size() == 0, "R10 byte in wait ignored", txQ.size(), 0);
    pulse(); idle(2);
    expData[8] = expData[8] & 8'h3C;
    chk(txQ.size() == 1, "R10 readback count", txQ.size(), 1);
    if (txQ.size() == 1) chk(txQ[0] == expData[8], "R10 data kept", txQ[0], expData[8]);
    txQ = {};
    busRst();

    // Final sweep of every data and status cell
    runWrite(8'hF3, 16'h0000, DW, 8'h00, 1'b1, "R5 final data sweep");
    runWrite(8'hF5, 16'h0000, SW, 8'h00, 1'b1, "R7 final status sweep");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule